// File: doc/BRIEF.md
# Dual-Bank Endpoint Receive Buffer

This block is the receive store of a single OUT-direction endpoint. It holds two packet banks that alternate, so that one packet can be arriving while the previous one waits for software. Bytes come in on a byte-wide packet interface (valid, data, last). Each packet is written into the bank that is next in turn, provided that bank is free. If both banks hold unread packets, the block raises a not-ready indication and throws away any packet that starts while it is raised.

Software reaches the block through a small byte register window with four addresses:

| Address | Name | Behaviour |
|---|---|---|
| 0 | Data port | Each read strobe returns the next byte of the bank selected for reading. |
| 1 | Size | Byte count of the packet in the selected bank. |
| 2 | Status | Data-available, overrun and not-ready bits. |
| 3 | Trigger | Write-only. Writing 1 to bit 5 releases the selected bank. |

A release clears the bank and makes it free for a later packet. The read selection then moves to the other bank, so packets reach software in the order they arrived. A bank is never released by reading its data out; only the trigger releases it.

Top module: `rxpp_endpoint`

## Requirements
- R1: After reset:
  - the size register (address 1) reads 0x00;
  - the status register (address 2) reads 0x00;
  - `pkt_nak` is 0;
  - the trigger register (address 3) reads 0x00.
- R2: When a packet of N bytes completes into the bank selected for reading, the size register reads N. Status bit 0 (data available) then reads 1.
- R3: Each cycle with `cpu_rd` high at address 0 returns the next byte of the selected packet, in arrival order, and advances by one. Once all stored bytes have been returned, further reads return 0x00.
- R4: Two packets can be stored at the same time. After the first is released, the size register and the data port present the second packet.
- R5: While both banks hold unread packets:
  - `pkt_nak` is 1;
  - status bit 2 reads 1;
  - a packet that starts in this state is discarded entirely and never appears to software.
- R6: A bank holds at most 64 bytes. For a longer packet:
  - the first 64 bytes are kept;
  - the size register reads 64;
  - status bit 1 (overrun) reads 1 while that packet is selected.
- R7: Writing a byte with bit 5 set to address 3 releases the selected bank one cycle after the write. If no other packet is pending, size then reads 0 and status bit 0 reads 0.
- R8: The following have no effect on the banks, the size or the status:
  - writes to address 3 with bit 5 clear, including writes that set reserved bits 7 and 3;
  - writes to any other address.

  Address 3 always reads 0x00.
- R9: A release trigger issued while no packet is pending is ignored. The next packet is received into the selected bank and read normally.
- R10: After a release, the data port restarts at the first byte of the newly selected packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_valid | input | 1 | Packet byte present this cycle |
| pkt_data | input | 8 | Packet byte |
| pkt_last | input | 1 | This byte ends the packet |
| pkt_nak | output | 1 | Both banks hold unread packets; a new packet is refused |
| cpu_addr | input | 2 | Register address: 0 data, 1 size, 2 status, 3 trigger |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Data port read strobe (advances the byte index at address 0) |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |

## Verification
Some properties are checked by assertions on every cycle:
- no byte is written into a bank that already holds a complete packet;
- a bank count never exceeds the bank depth;
- not-ready is raised only when both banks are full;
- a release clears its bank in the next cycle;
- an ignored release leaves the read selection unchanged;
- the trigger address always reads zero.

Other behaviours only the bench scenarios can show:
- packet order across releases;
- the byte contents returned through the data port;
- truncation of packets longer than a bank;
- that a packet refused under not-ready never reappears;
- that trigger writes without bit 5 leave the visible size and status untouched.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int unsigned NBANK = 2;

  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_BUSY = 2'd1,
    FILL_DROP = 2'd2
  } fill_state_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_SIZE = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_TRIG = 2'd3;
  localparam int unsigned TRIG_RELEASE_BIT = 5;

  // Saturating byte count: stays at the bank depth once reached.
  function automatic int unsigned sat_incr(int unsigned cnt, int unsigned depth);
    return (cnt < depth) ? cnt + 1 : depth;
  endfunction

  // Size seen by software: count only when the bank holds a complete packet.
  function automatic logic [7:0] visible_size(logic full, int unsigned cnt);
    return full ? 8'(cnt) : 8'd0;
  endfunction
endpackage

// File: rtl/rxpp_bank.sv
module rxpp_bank #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              clr,
  input  logic [CNT_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              ovr
);
  import rxpp_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              room;

  assign room = (count < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en && room) mem[count[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      full  <= 1'b0;
      ovr   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      full  <= 1'b0;
      ovr   <= 1'b0;
    end else if (wr_en) begin
      count <= CNT_W'(sat_incr(count, DEPTH));
      if (!room)   ovr  <= 1'b1;
      if (wr_last) full <= 1'b1;
    end
  end

  assign rd_data = (rd_idx < count) ? mem[rd_idx[IDX_W-1:0]] : '0;

  assert_no_write_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!full && count == '0 && !ovr));
endmodule

// File: rtl/rxpp_fill.sv
module rxpp_fill (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_valid,
  input  logic       pkt_last,
  input  logic [1:0] full,
  output logic [1:0] wr_en,
  output logic       nak,
  output logic       wr_sel
);
  import rxpp_pkg::*;

  fill_state_e state;
  logic        accept;
  logic        done_pkt;

  assign nak      = full[wr_sel];
  assign accept   = pkt_valid && ((state == FILL_BUSY) || (state == FILL_IDLE && !full[wr_sel]));
  assign done_pkt = accept && pkt_last;

  always_comb begin
    for (int b = 0; b < 2; b++) wr_en[b] = accept && (wr_sel == 1'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FILL_IDLE;
      wr_sel <= 1'b0;
    end else begin
      if (done_pkt) wr_sel <= ~wr_sel;
      unique case (state)
        FILL_IDLE: if (pkt_valid && !pkt_last) state <= full[wr_sel] ? FILL_DROP : FILL_BUSY;
        FILL_BUSY: if (pkt_valid && pkt_last)  state <= FILL_IDLE;
        FILL_DROP: if (pkt_valid && pkt_last)  state <= FILL_IDLE;
        default:   state <= FILL_IDLE;
      endcase
    end
  end

  assert_nak_both_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> (full == 2'b11));
  assert_drop_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FILL_DROP) |-> (wr_en == 2'b00));
  assert_one_bank_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/rxpp_cpu_regs.sv
module rxpp_cpu_regs #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cpu_addr,
  input  logic                       cpu_wr,
  input  logic                       cpu_rd,
  input  logic [7:0]                 cpu_wdata,
  input  logic [1:0]                 full,
  input  logic [1:0]                 ovr,
  input  logic [1:0][CNT_W-1:0]      count,
  input  logic [1:0][DATA_W-1:0]     bank_rdata,
  input  logic                       nak,
  output logic                       rd_sel,
  output logic [CNT_W-1:0]           rd_idx,
  output logic [1:0]                 clr,
  output logic [7:0]                 cpu_rdata
);
  import rxpp_pkg::*;

  logic             rel_pulse;
  logic             release_ok;
  logic             pop;
  logic [CNT_W-1:0] sel_cnt;
  logic             sel_full;

  assign sel_cnt    = count[rd_sel];
  assign sel_full   = full[rd_sel];
  assign release_ok = rel_pulse && sel_full;
  assign pop        = cpu_rd && (cpu_addr == ADDR_DATA) && sel_full && (rd_idx < sel_cnt);

  always_comb begin
    for (int b = 0; b < 2; b++) clr[b] = release_ok && (rd_sel == 1'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_pulse <= 1'b0;
      rd_sel    <= 1'b0;
      rd_idx    <= '0;
    end else begin
      rel_pulse <= cpu_wr && (cpu_addr == ADDR_TRIG) && cpu_wdata[TRIG_RELEASE_BIT];
      if (release_ok) begin
        rd_sel <= ~rd_sel;
        rd_idx <= '0;
      end else if (pop) begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (cpu_addr)
      ADDR_DATA: cpu_rdata = sel_full ? 8'(bank_rdata[rd_sel]) : 8'h00;
      ADDR_SIZE: cpu_rdata = visible_size(sel_full, sel_cnt);
      ADDR_STAT: cpu_rdata = {5'b0, nak, sel_full & ovr[rd_sel], sel_full};
      default:   cpu_rdata = 8'h00;
    endcase
  end

  assert_trig_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == ADDR_TRIG) |-> (cpu_rdata == 8'h00));
  assert_empty_release_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_pulse && !sel_full) |=> $stable(rd_sel));
  assert_avail_has_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == ADDR_SIZE && sel_full) |-> (cpu_rdata != 8'h00));
  assert_release_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    release_ok |=> (rd_idx == '0));
endmodule

// File: rtl/rxpp_endpoint.sv
module rxpp_endpoint #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              pkt_last,
  output logic              pkt_nak,
  input  logic [1:0]        cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata
);
  import rxpp_pkg::*;

  logic [1:0]              wr_en;
  logic [1:0]              clr;
  logic [1:0]              full;
  logic [1:0]              ovr;
  logic [1:0][CNT_W-1:0]   count;
  logic [1:0][DATA_W-1:0]  bank_rdata;
  logic                    wr_sel;
  logic                    rd_sel;
  logic [CNT_W-1:0]        rd_idx;

  rxpp_fill u_fill (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_last(pkt_last),
    .full(full), .wr_en(wr_en), .nak(pkt_nak), .wr_sel(wr_sel)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rxpp_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[b]), .wr_data(pkt_data),
      .wr_last(pkt_last), .clr(clr[b]), .rd_idx(rd_idx),
      .rd_data(bank_rdata[b]), .count(count[b]), .full(full[b]), .ovr(ovr[b])
    );
  end

  rxpp_cpu_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .full(full), .ovr(ovr),
    .count(count), .bank_rdata(bank_rdata), .nak(pkt_nak),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .clr(clr), .cpu_rdata(cpu_rdata)
  );

  assert_fifo_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full[rd_sel] == 1'b0) |-> (full[~rd_sel] == 1'b0));
  assert_wr_sel_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full == 2'b00) |-> (wr_sel == rd_sel));
endmodule

// File: tb/rxpp_endpoint_tb.sv
module rxpp_endpoint_tb;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_valid = 1'b0;
  logic [7:0] pkt_data = 8'h00;
  logic       pkt_last = 1'b0;
  logic       pkt_nak;
  logic [1:0] cpu_addr = 2'd1;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rxpp_endpoint u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_last(pkt_last), .pkt_nak(pkt_nak), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  function automatic logic [7:0] pat(int id, int i);
    return 8'((id * 37 + i * 5 + 1) & 255);
  endfunction

  function automatic int kept(int len);
    return (len > DEPTH) ? DEPTH : len;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send_pkt(int id, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pkt_valid = 1'b1;
      pkt_data  = pat(id, i);
      pkt_last  = (i == len - 1);
    end
    @(negedge clk);
    pkt_valid = 1'b0;
    pkt_last  = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output int v);
    @(negedge clk);
    cpu_addr = a;
    #1 v = cpu_rdata;
  endtask

  task automatic pop(output int v);
    @(negedge clk);
    cpu_addr = 2'd0;
    cpu_rd   = 1'b1;
    #1 v = cpu_rdata;
    @(negedge clk);
    cpu_rd   = 1'b0;
  endtask

  task automatic trig(logic [7:0] val, logic [1:0] a = 2'd3);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = val;
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr    = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_reg(2'd1, v); chk("R1 size", v, 0);
    rd_reg(2'd2, v); chk("R1 status", v, 0);
    chk("R1 nak", int'(pkt_nak), 0);
    rd_reg(2'd3, v); chk("R1 trig", v, 0);

    for (int la = 1; la <= DEPTH + 2; la++) begin
      int lb;
      int ida;
      int idb;
      lb  = ((la * 7) % (DEPTH + 2)) + 1;
      ida = la * 2;
      idb = la * 2 + 1;

      send_pkt(ida, la);
      rd_reg(2'd1, v); chk("R2 size", v, kept(la));
      rd_reg(2'd2, v); chk("R2/R6 status", v, 1 + ((la > DEPTH) ? 2 : 0));
      chk("R2 nak clear", int'(pkt_nak), 0);

      send_pkt(idb, lb);
      chk("R5 nak", int'(pkt_nak), 1);
      rd_reg(2'd2, v); chk("R5 status nak", (v >> 2) & 1, 1);
      rd_reg(2'd1, v); chk("R4 size first", v, kept(la));

      if (la % 8 == 0) send_pkt(99, 5);

      for (int i = 0; i < kept(la); i++) begin
        pop(v); chk("R3 data", v, int'(pat(ida, i)));
      end
      pop(v); chk("R3 past end", v, 0);

      trig(8'hDF);
      trig(8'h20, 2'd1);
      rd_reg(2'd1, v); chk("R8 size unchanged", v, kept(la));
      rd_reg(2'd3, v); chk("R8 trig reads zero", v, 0);

      trig(8'h20);
      rd_reg(2'd1, v); chk("R4 size second", v, kept(lb));
      rd_reg(2'd2, v); chk("R4/R6 status second", v, 1 + ((lb > DEPTH) ? 2 : 0));
      chk("R7 nak after release", int'(pkt_nak), 0);
      pop(v); chk("R10 restart", v, int'(pat(idb, 0)));
      if (lb > 1) begin
        pop(v); chk("R10 second byte", v, int'(pat(idb, 1)));
      end

      trig(8'hFF);
      rd_reg(2'd1, v); chk("R7 size empty", v, 0);
      rd_reg(2'd2, v); chk("R7 status empty", v, 0);

      trig(8'h20);
      rd_reg(2'd1, v); chk("R9 ignored size", v, 0);
    end

    send_pkt(7, 3);
    rd_reg(2'd1, v); chk("R9 after spurious", v, 3);
    pop(v); chk("R9 data", v, int'(pat(7, 0)));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule